// File: doc/BRIEF.md
# Page Reed-Solomon Parity Engine

A streaming Reed-Solomon encoder and checker for one flash page. Symbols are 10 bits wide over GF(2^10) with primitive polynomial x^10+x^3+1. The generator polynomial has six consecutive roots alpha^0 through alpha^5, so each page carries six 10-bit parity symbols. Each data byte enters as one symbol. It is bit-inverted and zero-extended to 10 bits first, so a blank page (all 0xFF) yields zero true parity and all-ones inverted parity.

In generate mode the host streams the page bytes and then reads the parity from a register bank. The parity is packed into eight bytes, each presented bit-reversed, in both a true and an inverted copy. In check mode the host streams the page bytes and then the six stored parity symbols, highest symbol first. The engine flags a nonzero remainder and exposes that remainder in the true bank, where software can locate and correct errors.

Top module: `rs_page_parity`

## Requirements
- R1: After reset all six remainder stages are zero, the mode bits are clear, and the symbol count is zero. Bank reads then show words 0..6 as 0x0000, word 7 as 0x000F, words 8..15 as 0x00FF and word 16 as 0x0000.
- R2: In generate mode, PAGE_BYTES accepted strobes leave in the stages the parity p(x) = u(x)·x^6 mod g(x). Here u(x) has the inverted bytes as coefficients, the first byte at the highest degree, and stage k holds the x^k coefficient. During this data phase sym_i[9:8] is ignored.
- R3: A page of all 0xFF bytes in generate mode reads back as 0x00FF on all eight inverted-bank words.
- R4: The remainder is packed into a 64-bit vector V, with stage k at V[10·(5−k)+9 : 10·(5−k)]. Logical byte b is V[8b+7:8b]. Word b (0..7) holds logical byte b bit-reversed. Word 8+b holds the complement of word b in its low byte, except that the padding bits stay 1. The upper byte of every word is zero.
- R5: The four padding bits V[63:60] appear as bits 3:0 of words 7 and 15 and always read 1.
- R6: In check mode (control bit 6 = 0) the stream is PAGE_BYTES inverted data symbols followed by six 10-bit parity symbols, fed as-is, highest stage first. Word 16 bit 7 reads 1 exactly when all PAGE_BYTES+6 symbols have been absorbed and the remainder is nonzero. Otherwise it reads 0.
- R7: After a check pass the true bank holds c(x)·x^6 mod g(x) of the received word c. It is zero for an intact codeword.
- R8: A control write with bit 7 set zeroes the stages and the count on that edge. Bit 7 is not retained. A strobe in the same cycle as any control write is dropped.
- R9: While control bit 5 (enable) is 0, strobes change neither the stages nor the count.
- R10: Strobes after the pass length is reached are ignored. The length is PAGE_BYTES in generate mode and PAGE_BYTES+6 in check mode.
- R11: Read addresses 17 and above return 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 8 | Control value: bit 7 clear, bit 6 generate, bit 5 enable |
| strb_i | input | 1 | Symbol strobe |
| sym_i | input | 10 | Data byte in bits 7:0, or a full parity symbol in check mode |
| rd_addr_i | input | 5 | Register read word address |
| rd_data_o | output | 16 | Register read data (combinational) |

## Verification
The bench builds its own GF(2^10) arithmetic from log tables. It checks generated parity by evaluating the received word at all six roots. A wrong generator root, a wrong byte inversion or a wrong shift direction would leave a nonzero syndrome. It checks a corrupted check pass by comparing the remainder, evaluated at each root, with the syndrome times alpha^(6i). A wrong packing, a missing bit reversal or a lost padding bit shows up there as a mismatched bank word. The bench also targets these cases:
- Corruption in the first byte, in the last byte, and in the stored parity symbols. An off-by-one pass length would miss one of these.
- Junk in sym_i[9:8] during the data phase.
- Strobes while disabled, after the pass ends, and in the same cycle as a clearing control write. Any of these, if absorbed, would shift the parity.

// File: rtl/rs_pkg.sv
package rs_pkg;
  localparam int SYM_W      = 10;
  localparam int NPAR       = 6;
  localparam logic [SYM_W:0] FIELD_POLY = 11'h409;
  localparam int BANK_BYTES = (NPAR * SYM_W + 7) / 8;
  localparam int PAD_BITS   = BANK_BYTES * 8 - NPAR * SYM_W;
  localparam int ADDR_W     = $clog2(2 * BANK_BYTES + 1);
  localparam int REG_W      = 16;

  typedef logic [SYM_W-1:0] sym_t;
  typedef logic [NPAR-1:0][SYM_W-1:0] par_vec_t;

  function automatic sym_t gf_mul(sym_t a, sym_t b);
    sym_t acc, sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < SYM_W; i++) begin
      if (b[i]) acc ^= sh;
      sh = sh[SYM_W-1] ? ((sh << 1) ^ FIELD_POLY[SYM_W-1:0]) : (sh << 1);
    end
    return acc;
  endfunction

  // product of (x + alpha^i) for i = 0..NPAR-1, monic term dropped
  function automatic par_vec_t gen_poly();
    sym_t     g [NPAR+1];
    sym_t     root;
    par_vec_t res;
    for (int k = 0; k <= NPAR; k++) g[k] = '0;
    g[0] = sym_t'(1);
    root = sym_t'(1);
    for (int i = 0; i < NPAR; i++) begin
      for (int k = NPAR; k > 0; k--) g[k] = g[k-1] ^ gf_mul(g[k], root);
      g[0] = gf_mul(g[0], root);
      root = gf_mul(root, sym_t'(2));
    end
    for (int k = 0; k < NPAR; k++) res[k] = g[k];
    return res;
  endfunction
endpackage

// File: rtl/rs_ctrl.sv
module rs_ctrl
  import rs_pkg::*;
#(
  parameter int PAGE_BYTES = 512
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ctrl_we_i,
  input  logic [7:0] ctrl_wdata_i,
  input  logic       strb_i,
  input  sym_t       sym_i,
  output logic       clr_o,
  output logic       adv_o,
  output sym_t       feed_o,
  output logic       gen_mode_o,
  output logic       full_o
);
  localparam int CODE_N = PAGE_BYTES + NPAR;
  localparam int CNT_W  = $clog2(CODE_N + 1);
  localparam logic [CNT_W-1:0] DATA_LEN = CNT_W'(PAGE_BYTES);
  localparam logic [CNT_W-1:0] CODE_LEN = CNT_W'(CODE_N);
  localparam int CLR_BIT = 7;
  localparam int GEN_BIT = 6;
  localparam int EN_BIT  = 5;

  logic             gen_q, en_q;
  logic [CNT_W-1:0] cnt_q, limit;
  logic             unused_wdata;

  assign unused_wdata = ^ctrl_wdata_i[4:0];
  assign limit      = gen_q ? DATA_LEN : CODE_LEN;
  assign clr_o      = ctrl_we_i & ctrl_wdata_i[CLR_BIT];
  assign adv_o      = strb_i & en_q & ~ctrl_we_i & (cnt_q < limit);
  assign feed_o     = (cnt_q < DATA_LEN) ? {{(SYM_W-8){1'b0}}, ~sym_i[7:0]} : sym_i;
  assign gen_mode_o = gen_q;
  assign full_o     = (cnt_q == CODE_LEN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gen_q <= 1'b0;
      en_q  <= 1'b0;
      cnt_q <= '0;
    end else if (ctrl_we_i) begin
      gen_q <= ctrl_wdata_i[GEN_BIT];
      en_q  <= ctrl_wdata_i[EN_BIT];
      if (ctrl_wdata_i[CLR_BIT]) cnt_q <= '0;
    end else if (adv_o) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assert_cnt_bound_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CODE_LEN);
  assert_clear_cnt_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we_i && ctrl_wdata_i[CLR_BIT]) |=> (cnt_q == '0));
  assert_freeze_cnt_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q && !ctrl_we_i) |=> $stable(cnt_q));
endmodule

// File: rtl/rs_lfsr.sv
module rs_lfsr
  import rs_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     clr_i,
  input  logic     adv_i,
  input  sym_t     sym_i,
  output par_vec_t rem_o
);
  localparam par_vec_t GEN = gen_poly();

  sym_t rem_q [NPAR];
  sym_t fb;

  assign fb = sym_i ^ rem_q[NPAR-1];

  for (genvar k = 0; k < NPAR; k++) begin : g_stage
    sym_t prod, nxt;
    assign prod = gf_mul(fb, GEN[k]);
    if (k == 0) begin : g_low
      assign nxt = prod;
    end else begin : g_up
      assign nxt = rem_q[k-1] ^ prod;
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     rem_q[k] <= '0;
      else if (clr_i)  rem_q[k] <= '0;
      else if (adv_i)  rem_q[k] <= nxt;
    end
    assign rem_o[k] = rem_q[k];
  end

  assert_clear_stages_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (rem_o == '0));
  assert_hold_stages_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !clr_i) |=> $stable(rem_o));
endmodule

// File: rtl/rs_reg_bank.sv
module rs_reg_bank
  import rs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  par_vec_t          rem_i,
  input  logic              err_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [REG_W-1:0]  rd_data_o
);
  localparam int VEC_W = BANK_BYTES * 8;
  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(2 * BANK_BYTES);
  localparam logic [ADDR_W-1:0] LAST_T    = ADDR_W'(BANK_BYTES - 1);
  localparam logic [ADDR_W-1:0] LAST_I    = ADDR_W'(2 * BANK_BYTES - 1);

  logic [VEC_W-1:0] packed_v;
  logic [7:0] true_b [BANK_BYTES];
  logic [7:0] pad_b  [BANK_BYTES];
  logic [7:0] inv_b  [BANK_BYTES];

  always_comb begin
    packed_v = '1;
    for (int k = 0; k < NPAR; k++) packed_v[SYM_W*(NPAR-1-k) +: SYM_W] = rem_i[k];
  end

  for (genvar b = 0; b < BANK_BYTES; b++) begin : g_byte
    for (genvar j = 0; j < 8; j++) begin : g_bit
      assign true_b[b][j] = packed_v[8*b+7-j];
      assign pad_b[b][j]  = ((8*b+7-j) >= NPAR*SYM_W);
    end
    assign inv_b[b] = ~true_b[b] | pad_b[b];
  end

  always_comb begin
    rd_data_o = '0;
    for (int b = 0; b < BANK_BYTES; b++) begin
      if (rd_addr_i == ADDR_W'(b))              rd_data_o[7:0] = true_b[b];
      if (rd_addr_i == ADDR_W'(b + BANK_BYTES)) rd_data_o[7:0] = inv_b[b];
    end
    if (rd_addr_i == STAT_ADDR) rd_data_o[7] = err_i;
  end

  assert_pad_ones_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_i == LAST_T || rd_addr_i == LAST_I) |-> (&rd_data_o[PAD_BITS-1:0]));
  assert_upper_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[REG_W-1:8] == '0);
endmodule

// File: rtl/rs_page_parity.sv
module rs_page_parity
  import rs_pkg::*;
#(
  parameter int PAGE_BYTES = 512
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic [7:0]        ctrl_wdata_i,
  input  logic              strb_i,
  input  logic [SYM_W-1:0]  sym_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [REG_W-1:0]  rd_data_o
);
  logic     clr, adv, gen_mode, full, err;
  sym_t     feed;
  par_vec_t rem;

  rs_ctrl #(.PAGE_BYTES(PAGE_BYTES)) u_ctrl (
    .clk_i, .rst_ni, .ctrl_we_i, .ctrl_wdata_i, .strb_i, .sym_i,
    .clr_o(clr), .adv_o(adv), .feed_o(feed), .gen_mode_o(gen_mode), .full_o(full)
  );

  rs_lfsr u_lfsr (
    .clk_i, .rst_ni, .clr_i(clr), .adv_i(adv), .sym_i(feed), .rem_o(rem)
  );

  // error is only meaningful once a full check pass has been absorbed
  assign err = ~gen_mode & full & (|rem);

  rs_reg_bank u_bank (
    .clk_i, .rst_ni, .rem_i(rem), .err_i(err), .rd_addr_i, .rd_data_o
  );

  assert_err_full_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err && !ctrl_we_i) |=> (err || $changed(rem)));
endmodule

// File: tb/rs_page_parity_tb.sv
`timescale 1ns/1ps
module rs_page_parity_tb_top;
  localparam int PB = 512;

  logic clk = 1'b0, rst_n = 1'b0, cwe = 1'b0, strb = 1'b0;
  logic [7:0]  cwd = '0;
  logic [9:0]  sym = '0;
  logic [4:0]  addr = '0;
  logic [15:0] rdata;

  always #5 clk = ~clk;

  rs_page_parity #(.PAGE_BYTES(PB)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_we_i(cwe), .ctrl_wdata_i(cwd),
    .strb_i(strb), .sym_i(sym), .rd_addr_i(addr), .rd_data_o(rdata)
  );

  int  n_chk = 0, n_fail = 0;
  bit  finished = 0;
  int  exp_t [0:2045];
  int  log_t [0:1023];
  int  in_b  [0:PB-1];
  int  in_p  [0:5];
  int  par   [0:5];
  int  rem   [0:5];

  function automatic int gm(int a, int b);
    if (a == 0 || b == 0) return 0;
    return exp_t[(log_t[a] + log_t[b]) % 1023];
  endfunction

  function automatic int apow(int e);
    return exp_t[e % 1023];
  endfunction

  function automatic int bitrev8(int x);
    int r = 0;
    for (int j = 0; j < 8; j++) if (x[j]) r |= (1 << (7 - j));
    return r;
  endfunction

  // evaluate the streamed word at alpha^i
  function automatic int syn(int i, int nsym);
    int a = apow(i);
    int acc = 0;
    for (int k = 0; k < nsym; k++) begin
      int s;
      s = (k < PB) ? ((~in_b[k]) & 255) : in_p[k-PB];
      acc = gm(acc, a) ^ s;
    end
    return acc;
  endfunction

  function automatic int rem_eval(int i);
    int a = apow(i);
    int acc = 0;
    for (int k = 5; k >= 0; k--) acc = gm(acc, a) ^ rem[k];
    return acc;
  endfunction

  task automatic chk(string req, string what, int act, int expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic wr_ctrl(int v, bit with_strb);
    @(negedge clk);
    cwe = 1'b1; cwd = v[7:0];
    strb = with_strb; sym = 10'h3A5;
    @(negedge clk);
    cwe = 1'b0; strb = 1'b0;
  endtask

  task automatic feed(int n, bit junk);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      strb = 1'b1;
      if (i < PB) sym = {(junk ? i[1:0] : 2'b00), in_b[i][7:0]};
      else        sym = in_p[i-PB][9:0];
    end
    @(negedge clk);
    strb = 1'b0;
  endtask

  task automatic feed_junk(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      strb = 1'b1; sym = 10'(i * 37 + 5);
    end
    @(negedge clk);
    strb = 1'b0;
  endtask

  task automatic rd(int a, output int d);
    @(negedge clk);
    addr = a[4:0];
    #1 d = int'(rdata);
  endtask

  // read both banks, check layout rules, unpack the remainder
  task automatic read_rem();
    logic [63:0] v;
    int t, iv;
    for (int b = 0; b < 8; b++) begin
      rd(b, t);
      rd(b + 8, iv);
      chk("R4", "true word upper byte", t >> 8, 0);
      chk("R4", "inverted word", iv, ((~t) & 255) | (b == 7 ? 15 : 0));
      if (b == 7) chk("R5", "padding bits", t & 15, 15);
      v[8*b +: 8] = bitrev8(t)[7:0];
    end
    for (int k = 0; k < 6; k++) rem[k] = int'(v[10*(5-k) +: 10]);
  endtask

  task automatic run_page(int err_pos);
    int st;
    // generate with junk in the upper symbol bits
    wr_ctrl(8'hE0, 1'b0);
    feed(PB, 1'b1);
    read_rem();
    for (int k = 0; k < 6; k++) par[k] = rem[k];
    for (int j = 0; j < 6; j++) in_p[j] = par[5-j];
    for (int i = 0; i < 6; i++) chk("R2", "codeword syndrome", syn(i, PB + 6), 0);
    // extra strobes after the pass
    feed_junk(7);
    read_rem();
    for (int k = 0; k < 6; k++) chk("R10", "parity after overrun", rem[k], par[k]);
    // clean check pass
    wr_ctrl(8'hA0, 1'b0);
    feed(PB + 6, 1'b0);
    rd(16, st);
    chk("R6", "clean status", st, 0);
    read_rem();
    for (int k = 0; k < 6; k++) chk("R7", "clean remainder", rem[k], 0);
    feed_junk(3);
    rd(16, st);
    chk("R10", "status after check overrun", st, 0);
    // corrupted pass
    if (err_pos < PB) in_b[err_pos] ^= 8'h5A;
    else              in_p[err_pos-PB] ^= 10'h201;
    wr_ctrl(8'hA0, 1'b0);
    feed(PB + 6, 1'b0);
    rd(16, st);
    chk("R6", "error status", st, 16'h0080);
    read_rem();
    for (int i = 0; i < 6; i++)
      chk("R7", "remainder at root", rem_eval(i), gm(syn(i, PB + 6), apow(6 * i)));
    if (err_pos < PB) in_b[err_pos] ^= 8'h5A;
    else              in_p[err_pos-PB] ^= 10'h201;
  endtask

  task automatic finish_run();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    int d, lcg;
    int x = 1;
    for (int i = 0; i < 1023; i++) begin
      exp_t[i] = x; exp_t[i+1023] = x;
      log_t[x] = i;
      x = x << 1;
      if (x & 1024) x ^= 32'h409;
    end
    log_t[0] = 0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // reset state and address map
    for (int a = 0; a < 32; a++) begin
      rd(a, d);
      if (a < 7)       chk("R1", "reset true word", d, 0);
      else if (a == 7) chk("R1", "reset true last word", d, 16'h000F);
      else if (a < 16) chk("R1", "reset inverted word", d, 16'h00FF);
      else if (a == 16) chk("R1", "reset status", d, 0);
      else             chk("R11", "unmapped address", d, 0);
    end
    // strobes with enable clear after reset
    feed_junk(9);
    rd(0, d); chk("R9", "disabled after reset", d, 0);
    rd(4, d); chk("R9", "disabled after reset", d, 0);

    // blank page
    for (int i = 0; i < PB; i++) in_b[i] = 255;
    run_page(0);
    wr_ctrl(8'hE0, 1'b0);
    feed(PB, 1'b0);
    for (int b = 0; b < 8; b++) begin
      rd(b + 8, d); chk("R3", "blank inverted parity", d, 16'h00FF);
    end

    // incrementing page, error in last data byte
    for (int i = 0; i < PB; i++) in_b[i] = i & 255;
    run_page(PB - 1);

    // pseudo-random page, errors in a parity symbol and mid page
    lcg = 12345;
    for (int i = 0; i < PB; i++) begin
      lcg = lcg * 1103515245 + 12345;
      in_b[i] = (lcg >>> 16) & 255;
    end
    run_page(PB + 5);
    run_page(200);

    // zero page, single byte set, error in first parity symbol
    for (int i = 0; i < PB; i++) in_b[i] = 0;
    in_b[300] = 8'h81;
    run_page(PB);

    // freeze: enable off, stages must hold
    wr_ctrl(8'hE0, 1'b0);
    feed(PB, 1'b0);
    read_rem();
    for (int k = 0; k < 6; k++) par[k] = rem[k];
    wr_ctrl(8'h40, 1'b0);
    feed_junk(20);
    read_rem();
    for (int k = 0; k < 6; k++) chk("R9", "parity while disabled", rem[k], par[k]);

    // clear with a simultaneous strobe
    wr_ctrl(8'hE0, 1'b1);
    for (int b = 0; b < 7; b++) begin
      rd(b, d); chk("R8", "cleared true word", d, 0);
    end
    rd(7, d); chk("R8", "cleared last word", d, 16'h000F);
    feed(PB, 1'b0);
    read_rem();
    for (int k = 0; k < 6; k++) chk("R8", "parity after clear with strobe", rem[k], par[k]);

    finish_run();
  end
endmodule